// File: doc/BRIEF.md
# Phase Offset Calibration Sequencer

This block re-zeroes the phase offset applied to a clock path without letting the outputs see a jump. A one-cycle trigger starts a calibration run. The block requests holdover first. It then walks the applied offset down to zero one step at a time and pulses a reset to the output and feedback dividers. After that it walks the offset back up to the programmed value and drops holdover only after the offset has arrived. The calibration flag clears itself when the run completes, so software can poll it to learn when the run is done.

Outside a calibration run, the applied offset follows the programmed offset in one of two ways. When slewing is off, a new programmed value is loaded in one cycle. When slewing is on, the applied offset slews toward the new value by one LSB each step interval. The step interval is programmable in clock cycles, and one tick counter times every ramp. The loop filter and oscillator lie outside this block.

Top module: `phase_cal_seq`

## Requirements
- R1: While reset is low, `cal_active`, `holdover_req` and `div_reset` are 0 and `applied_offset` is 0.
- R2: A `cal_start` pulse seen while idle makes `cal_active` and `holdover_req` 1 from the next cycle. Both stay 1 until the run ends. With the applied and programmed offsets both already 0, a run lasts exactly 4 cycles.
- R3: `applied_offset` does not change in the cycle in which `holdover_req` rises. A slew step that would land on the same edge as an accepted trigger is dropped.
- R4: During a run the offset is ramped to 0 before the divider reset. `div_reset` is only ever 1 while `applied_offset` is 0 and `holdover_req` is 1.
- R5: `div_reset` is a single-cycle pulse, given exactly once per calibration run.
- R6: After the divider reset, the offset ramps to `prog_offset`. `holdover_req` falls only once `applied_offset` equals `prog_offset`.
- R7: Every ramp, during calibration or in slew mode, changes `applied_offset` by exactly +1 or -1 (two's complement) per step.
- R8: Consecutive steps of one ramp are `step_interval`+1 cycles apart. The first step of a ramp comes `step_interval`+1 cycles after the ramp starts.
- R9: When idle with `auto_ramp`=0, `applied_offset` takes the value of `prog_offset` one cycle after it changes.
- R10: When idle with `auto_ramp`=1, a change of `prog_offset` is followed by a one-LSB-per-step ramp from the old value to the new one.
- R11: A `cal_start` pulse that arrives while a run is active has no effect. The run completes once, with one divider pulse, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | One-cycle pulse that writes 1 to the calibration bit |
| auto_ramp | input | 1 | 1: slew to new programmed values; 0: load them at once |
| prog_offset | input | OFS_W | Programmed phase offset, signed two's complement |
| step_interval | input | TICK_W | Ramp step period minus one, in clock cycles |
| cal_active | output | 1 | Self-clearing calibration bit, reads 1 while a run is active |
| holdover_req | output | 1 | Holdover request to the loop |
| div_reset | output | 1 | One-cycle reset to the output and feedback dividers |
| applied_offset | output | OFS_W | Phase offset currently applied, signed |

## Verification
A slew step and a calibration trigger can compete for the same clock edge. The bench sets slew mode and moves the programmed offset. It then raises the trigger in the cycle just before the fourth edge, the edge where, with an interval of 3, the first slew step would land. The run must win: holdover rises, the offset is still at its old value, and the later ramp-up starts from there. A second overlap places a trigger in the middle of a run. The bench judges it through the divider pulse count, the continuous holdover window and the absence of any later run.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_HOLD,
    CS_DOWN,
    CS_DRST,
    CS_UP
  } cal_state_e;

  typedef enum logic [1:0] {
    RM_FREEZE,
    RM_LOAD,
    RM_SLEW
  } ramp_mode_e;

endpackage

// File: rtl/pcs_ramp.sv
module pcs_ramp
  import pcs_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int TICK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ramp_mode_e              mode,
  input  logic signed [OFS_W-1:0] target,
  input  logic [TICK_W-1:0]       interval,
  output logic signed [OFS_W-1:0] applied,
  output logic                    at_target,
  output logic                    step_tick
);

  localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);
  localparam logic signed [OFS_W-1:0] OFS_ONE = OFS_W'(1);

  // one LSB toward the goal, signed compare
  function automatic logic signed [OFS_W-1:0] step_toward(
    input logic signed [OFS_W-1:0] cur,
    input logic signed [OFS_W-1:0] goal
  );
    if (goal > cur) return cur + OFS_ONE;
    else            return cur - OFS_ONE;
  endfunction

  logic [TICK_W-1:0] tick_cnt;

  assign at_target = (applied == target);
  assign step_tick = (mode == RM_SLEW) && !at_target && (tick_cnt == interval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      applied  <= '0;
    end else begin
      unique case (mode)
        RM_LOAD: begin
          applied  <= target;
          tick_cnt <= '0;
        end
        RM_SLEW: begin
          if (at_target) begin
            tick_cnt <= '0;
          end else if (step_tick) begin
            tick_cnt <= '0;
            applied  <= step_toward(applied, target);
          end else begin
            tick_cnt <= tick_cnt + TICK_ONE;
          end
        end
        default: tick_cnt <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_start,
  input  logic       auto_ramp,
  input  logic       at_target,
  output cal_state_e state,
  output ramp_mode_e mode,
  output logic       aim_zero
);

  cal_state_e state_nx;

  always_comb begin
    state_nx = state;
    mode     = RM_FREEZE;
    aim_zero = 1'b0;
    unique case (state)
      CS_IDLE: begin
        if (cal_start) state_nx = CS_HOLD;
        else           mode     = auto_ramp ? RM_SLEW : RM_LOAD;
      end
      CS_HOLD: state_nx = CS_DOWN;
      CS_DOWN: begin
        mode     = RM_SLEW;
        aim_zero = 1'b1;
        if (at_target) state_nx = CS_DRST;
      end
      CS_DRST: state_nx = CS_UP;
      CS_UP: begin
        mode = RM_SLEW;
        if (at_target) state_nx = CS_IDLE;
      end
      default: state_nx = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CS_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/phase_cal_seq.sv
module phase_cal_seq
  import pcs_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int TICK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_start,
  input  logic                    auto_ramp,
  input  logic signed [OFS_W-1:0] prog_offset,
  input  logic [TICK_W-1:0]       step_interval,
  output logic                    cal_active,
  output logic                    holdover_req,
  output logic                    div_reset,
  output logic signed [OFS_W-1:0] applied_offset
);

  cal_state_e              state;
  ramp_mode_e              mode;
  logic                    aim_zero;
  logic                    at_target;
  logic                    step_tick;
  logic signed [OFS_W-1:0] ramp_target;

  assign ramp_target = aim_zero ? '0 : prog_offset;

  pcs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_start (cal_start),
    .auto_ramp (auto_ramp),
    .at_target (at_target),
    .state     (state),
    .mode      (mode),
    .aim_zero  (aim_zero)
  );

  pcs_ramp #(.OFS_W(OFS_W), .TICK_W(TICK_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .target    (ramp_target),
    .interval  (step_interval),
    .applied   (applied_offset),
    .at_target (at_target),
    .step_tick (step_tick)
  );

  assign holdover_req = (state != CS_IDLE);
  assign cal_active   = (state != CS_IDLE);
  assign div_reset    = (state == CS_DRST);

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int OFS_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cal_start,
  input logic                    cal_active,
  input logic                    holdover_req,
  input logic                    div_reset,
  input logic                    step_tick,
  input logic signed [OFS_W-1:0] prog_offset,
  input logic signed [OFS_W-1:0] applied_offset
);

  localparam logic signed [OFS_W-1:0] C_ONE = OFS_W'(1);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!cal_active && !holdover_req && !div_reset && applied_offset == '0));

  assert_trigger_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!holdover_req && cal_start) |=> (holdover_req && cal_active));

  assert_hold_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover_req) |-> $stable(applied_offset));

  assert_zero_at_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset |-> (applied_offset == '0 && holdover_req));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset |=> !div_reset);

  assert_release_on_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdover_req) |-> ($past(applied_offset) == $past(prog_offset)));

  assert_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover_req && $past(holdover_req) && !$stable(applied_offset)) |->
      ((applied_offset == $past(applied_offset) + C_ONE) ||
       (applied_offset == $past(applied_offset) - C_ONE)));

  assert_step_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover_req && !$stable(applied_offset)) |-> $past(step_tick));

endmodule

bind phase_cal_seq pcs_checker #(.OFS_W(OFS_W)) u_pcs_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cal_start      (cal_start),
  .cal_active     (cal_active),
  .holdover_req   (holdover_req),
  .div_reset      (div_reset),
  .step_tick      (step_tick),
  .prog_offset    (prog_offset),
  .applied_offset (applied_offset)
);

// File: tb/test_phase_cal_seq.sv
module test_phase_cal_seq;

  localparam int OFS_W  = 8;
  localparam int TICK_W = 8;
  localparam int IVL    = 3;
  localparam int GAP    = IVL + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic auto_ramp = 1'b0;
  logic signed [OFS_W-1:0] prog_offset = '0;
  logic [TICK_W-1:0] step_interval = TICK_W'(IVL);
  logic cal_active, holdover_req, div_reset;
  logic signed [OFS_W-1:0] applied_offset;

  always #4 clk = ~clk;

  phase_cal_seq #(.OFS_W(OFS_W), .TICK_W(TICK_W)) i_phase_cal_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .cal_start      (cal_start),
    .auto_ramp      (auto_ramp),
    .prog_offset    (prog_offset),
    .step_interval  (step_interval),
    .cal_active     (cal_active),
    .holdover_req   (holdover_req),
    .div_reset      (div_reset),
    .applied_offset (applied_offset)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int exp_val[$];
  bit exp_gap[$];
  int cyc = 0;
  int last_chg = 0;
  int prev_val = 0;
  bit prev_div = 0;
  int div_count = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int v, input bit g);
    exp_val.push_back(v);
    exp_gap.push_back(g);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (int'(applied_offset) != prev_val) begin
        if (exp_val.size() == 0) begin
          chk(0, "R7 unexpected offset change", int'(applied_offset), prev_val);
        end else begin
          int e;
          bit g;
          e = exp_val.pop_front();
          g = exp_gap.pop_front();
          chk(int'(applied_offset) == e, "R7 offset sequence", int'(applied_offset), e);
          if (g) chk(cyc - last_chg == GAP, "R8 step spacing", cyc - last_chg, GAP);
        end
        last_chg = cyc;
        prev_val = int'(applied_offset);
      end
      if (div_reset) begin
        div_count++;
        chk(applied_offset == '0, "R4 offset zero at divider reset", int'(applied_offset), 0);
        chk(!prev_div, "R5 divider pulse width", 2, 1);
      end
      prev_div = div_reset;
    end
  end

  task automatic settle(input string tag);
    int t;
    t = 0;
    while ((cal_active || exp_val.size() != 0) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, tag, t, 0);
    repeat (GAP + 2) @(negedge clk);
  endtask

  task automatic pulse_start();
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cal_active && !holdover_req && !div_reset, "R1 flags in reset",
        int'({cal_active, holdover_req, div_reset}), 0);
    chk(applied_offset == '0, "R1 offset in reset", int'(applied_offset), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 direct load
    push(5, 0);
    prog_offset = 8'sd5;
    @(negedge clk);
    chk(int'(applied_offset) == 5, "R9 direct load", int'(applied_offset), 5);
    push(-3, 0);
    prog_offset = -8'sd3;
    @(negedge clk);
    chk(int'(applied_offset) == -3, "R9 direct load negative", int'(applied_offset), -3);
    repeat (2) @(negedge clk);

    // R10 slewed change -3 -> 2
    auto_ramp = 1'b1;
    push(-2, 0); push(-1, 1); push(0, 1); push(1, 1); push(2, 1);
    prog_offset = 8'sd2;
    settle("R10 slew finished");
    chk(int'(applied_offset) == 2, "R10 slew end value", int'(applied_offset), 2);

    // R2/R3/R6/R11 calibration from 2 with a retrigger mid-run
    d0 = div_count;
    push(1, 0); push(0, 1); push(1, 0); push(2, 1);
    pulse_start();
    chk(holdover_req && cal_active, "R2 holdover after trigger",
        int'({holdover_req, cal_active}), 3);
    chk(int'(applied_offset) == 2, "R3 offset held at holdover", int'(applied_offset), 2);
    repeat (5) @(negedge clk);
    pulse_start();
    settle("R6 run finished");
    chk(int'(applied_offset) == 2, "R6 back at programmed", int'(applied_offset), 2);
    chk(div_count - d0 == 1, "R11 one divider pulse per run", div_count - d0, 1);
    repeat (10) @(negedge clk);
    chk(!holdover_req, "R11 no second run", int'(holdover_req), 0);

    // calibration with a negative value, slew mode off
    auto_ramp = 1'b0;
    push(-2, 0);
    prog_offset = -8'sd2;
    repeat (2) @(negedge clk);
    d0 = div_count;
    push(-1, 0); push(0, 1); push(-1, 0); push(-2, 1);
    pulse_start();
    chk(holdover_req, "R2 holdover on negative run", int'(holdover_req), 1);
    settle("R6 negative run finished");
    chk(int'(applied_offset) == -2, "R6 negative target reached", int'(applied_offset), -2);
    chk(div_count - d0 == 1, "R5 one pulse negative run", div_count - d0, 1);

    // run with everything at zero: 4 busy cycles
    push(0, 0);
    prog_offset = '0;
    repeat (2) @(negedge clk);
    d0 = div_count;
    begin
      int busy;
      busy = 0;
      pulse_start();
      while (cal_active && busy < 50) begin
        busy++;
        @(negedge clk);
      end
      chk(busy == 4, "R2 run length at zero", busy, 4);
    end
    chk(div_count - d0 == 1, "R5 pulse at zero run", div_count - d0, 1);

    // trigger on the edge of the first slew step
    auto_ramp = 1'b1;
    repeat (2) @(negedge clk);
    push(1, 0); push(2, 1); push(3, 1);
    prog_offset = 8'sd3;
    repeat (3) @(negedge clk);
    pulse_start();
    chk(holdover_req, "R3 trigger wins over slew step", int'(holdover_req), 1);
    chk(int'(applied_offset) == 0, "R3 slew step dropped", int'(applied_offset), 0);
    settle("R6 collision run finished");
    chk(int'(applied_offset) == 3, "R6 collision target", int'(applied_offset), 3);
    chk(exp_val.size() == 0, "R7 all expected steps seen", exp_val.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule